// File: doc/BRIEF.md
# Read Strobe Gating and Resync Qualifier Controller

This block sits inside a double-data-rate memory controller on the read path. It starts when the controller issues a read command. First it waits through a blanking interval that depends on the CAS latency. Then it looks for the strobe-low indication that the byte lane reports during the read preamble. Once that indication is seen, it raises a gating preset that keeps the lane's capture registers enabled for the length of the burst.

A word-valid qualifier follows the preset after a programmable number of system clock cycles. Each resynchronised word holds two beats, so the qualifier stays high for half the burst length in cycles. One cycle after the last word of each burst, a single-cycle done pulse is raised.

The block also tells the lane whether resynchronisation should use the rising or the falling system clock edge. That choice is the programmed edge bit, inverted when the CAS latency is the half-cycle setting. A read issued while an earlier one is still being gated is queued, and its gating and qualifier windows then follow the earlier ones with no gap.

The mode (CAS latency, burst length, cycle offset, edge bit) is held in registers. These registers load only while the block is idle.

State machine:
- States:
  - IDLE: nothing in flight.
  - BLANK: the strobe indication is ignored.
  - HUNT: the block waits for the strobe-low indication.
  - STROBE: the preset is high.
  - DRAIN: the preset is low while the qualifier pipeline empties.
- Transitions:
  - IDLE→BLANK on a read command.
  - BLANK→HUNT when the blanking count ends.
  - HUNT→STROBE on the strobe-low indication.
  - STROBE→STROBE on a chained burst, when a read is queued at the burst's last cycle.
  - STROBE→DRAIN at the burst's last cycle with nothing queued.
  - DRAIN→IDLE when the drain count reaches zero.
  - DRAIN→BLANK on a fresh read command.

Top module: `rd_resync_ctl`

## Requirements
- R1: After reset `strobe_gate_preset`, `rd_word_valid`, `rd_burst_done` and `resync_on_fall` are all 0. The mode after reset is CAS code 0, burst code 0, offset 0, edge bit 0.
- R2: The mode registers load from `cfg_*` at a clock edge where `cfg_load` is 1, the block is idle and `rd_cmd` is 0. At any other time `cfg_load` has no effect on the outputs or on later read timing.
- R3: `resync_on_fall` equals `cfg_edge` XOR (CAS code == 1). The CAS codes are: 0 = 2 cycles, 1 = 2.5 cycles, 2 and 3 = 3 cycles.
- R4: `dqs_low` is ignored while idle, in the cycle of the read command, and for B cycles after it. B is 1 for CAS codes 0 and 1 and 2 for codes 2 and 3.
- R5: Suppose `dqs_low` is first honoured when driven in cycle c. Then the preset is high in cycles c+1 to c+H and low otherwise. H is the number of words per burst. The burst codes are: 0 = 2 beats (H=1), 1 = 4 beats (H=2), 2 and 3 = 8 beats (H=4).
- R6: `rd_word_valid` is high in cycles c+2+off to c+1+off+H, where off is the loaded 2-bit offset.
- R7: `rd_burst_done` is high for exactly one cycle, c+2+off+H, which is the cycle after each burst's last valid word.
- R8: A read command that arrives in BLANK, HUNT or STROBE is queued, up to PEND_MAX queued reads. Further commands are dropped. Queued bursts extend the preset and valid windows by H cycles each, with no gap, and each burst gives its own done pulse.
- R9: A read command that arrives during DRAIN starts a new blanking interval at once. The delayed qualifier of the earlier burst is still delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_cmd | input | 1 | Read command pulse |
| dqs_low | input | 1 | Strobe-low detect from the byte lane |
| cfg_load | input | 1 | Load request for the mode registers |
| cfg_cas | input | 2 | CAS latency code |
| cfg_burst | input | 2 | Burst length code |
| cfg_offset | input | OFS_W | Resync cycle offset |
| cfg_edge | input | 1 | Programmed resync edge bit |
| strobe_gate_preset | output | 1 | Capture-gating preset for the lane |
| rd_word_valid | output | 1 | Qualifier for resynchronised read words |
| rd_burst_done | output | 1 | One-cycle pulse after each burst |
| resync_on_fall | output | 1 | 1 selects the falling system clock edge |

## Verification
The bench builds the block with its defaults: a 2-bit offset and up to three queued reads. With only four CAS codes, four burst codes, four offsets and two edge values, every mode combination can be swept. For each one, the preset, valid and done traces are predicted cycle by cycle from the R4 to R7 formulas. Extra directed traces reach the queue saturation at three pending reads, a restart from DRAIN with the largest offset, and mode loads attempted while busy or together with a read.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

    localparam int CAS_W   = 2;
    localparam int BURST_W = 2;
    localparam int BLANK_W = 2;
    localparam int WORD_W  = 3;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_BLANK  = 3'd1,
        ST_HUNT   = 3'd2,
        ST_STROBE = 3'd3,
        ST_DRAIN  = 3'd4
    } rrc_state_e;

    typedef struct packed {
        logic [CAS_W-1:0]   cas;
        logic [BURST_W-1:0] burst;
        logic               edge_sel;
    } rrc_mode_t;

    // cycles after the command during which the strobe detect is ignored
    function automatic logic [BLANK_W-1:0] blank_cycles(input logic [CAS_W-1:0] cas);
        return (cas >= 2'd2) ? 2'd2 : 2'd1;
    endfunction

    // resynchronised words per burst (two beats per word)
    function automatic logic [WORD_W-1:0] words_per_burst(input logic [BURST_W-1:0] burst);
        logic [WORD_W-1:0] w;
        unique case (burst)
            2'd0:    w = 3'd1;
            2'd1:    w = 3'd2;
            default: w = 3'd4;
        endcase
        return w;
    endfunction

    function automatic logic is_half_cas(input logic [CAS_W-1:0] cas);
        return cas == 2'd1;
    endfunction

endpackage

// File: rtl/rrc_mode_regs.sv
module rrc_mode_regs
    import rrc_pkg::*;
#(
    parameter int OFS_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic [CAS_W-1:0]   cas_in,
    input  logic [BURST_W-1:0] burst_in,
    input  logic [OFS_W-1:0]   ofs_in,
    input  logic               edge_in,
    output rrc_mode_t          mode,
    output logic [OFS_W-1:0]   ofs,
    output logic               resync_on_fall
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode <= '0;
            ofs  <= '0;
        end else if (load_en) begin
            mode.cas      <= cas_in;
            mode.burst    <= burst_in;
            mode.edge_sel <= edge_in;
            ofs           <= ofs_in;
        end
    end

    // a half-cycle latency moves resync by 180 degrees: flip the edge
    assign resync_on_fall = mode.edge_sel ^ is_half_cas(mode.cas);

endmodule

// File: rtl/rrc_seq_fsm.sv
module rrc_seq_fsm
    import rrc_pkg::*;
#(
    parameter int OFS_W    = 2,
    parameter int PEND_MAX = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_cmd,
    input  logic               dqs_low,
    input  logic [BLANK_W-1:0] blank_len,
    input  logic [WORD_W-1:0]  word_len,
    input  logic [OFS_W:0]     drain_len,
    output logic               strobe_act,
    output logic               burst_last,
    output logic               idle
);

    localparam int PEND_W = $clog2(PEND_MAX + 1);
    localparam logic [PEND_W:0] PEND_CAP = (PEND_W + 1)'(PEND_MAX);

    rrc_state_e          state_q, state_d;
    logic [BLANK_W-1:0]  blank_q, blank_d;
    logic [WORD_W-1:0]   word_q,  word_d;
    logic [OFS_W:0]      drain_q, drain_d;
    logic [PEND_W-1:0]   pend_q,  pend_d;

    logic                accept_q;
    logic [PEND_W:0]     pend_inc;
    logic [PEND_W-1:0]   pend_sat;

    // commands arriving while a burst is being set up or gated are queued
    always_comb begin
        accept_q = rd_cmd && (state_q == ST_BLANK || state_q == ST_HUNT ||
                              state_q == ST_STROBE);
        pend_inc = {1'b0, pend_q} + {{PEND_W{1'b0}}, accept_q};
        pend_sat = (pend_inc > PEND_CAP) ? PEND_CAP[PEND_W-1:0] : pend_inc[PEND_W-1:0];
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        blank_d = blank_q;
        word_d  = word_q;
        drain_d = drain_q;
        pend_d  = pend_sat;
        unique case (state_q)
            ST_IDLE: begin
                if (rd_cmd) begin
                    state_d = ST_BLANK;
                    blank_d = blank_len;
                end
            end
            ST_BLANK: begin
                if (blank_q <= 2'd1) begin
                    state_d = ST_HUNT;
                end else begin
                    blank_d = blank_q - 2'd1;
                end
            end
            ST_HUNT: begin
                if (dqs_low) begin
                    state_d = ST_STROBE;
                    word_d  = word_len;
                end
            end
            ST_STROBE: begin
                if (word_q == 3'd1) begin
                    if (pend_sat != '0) begin
                        word_d = word_len;
                        pend_d = pend_sat - 1'b1;
                    end else begin
                        state_d = ST_DRAIN;
                        drain_d = drain_len;
                    end
                end else begin
                    word_d = word_q - 3'd1;
                end
            end
            ST_DRAIN: begin
                if (rd_cmd) begin
                    state_d = ST_BLANK;
                    blank_d = blank_len;
                end else if (drain_q == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    drain_d = drain_q - 1'b1;
                end
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            blank_q <= '0;
            word_q  <= '0;
            drain_q <= '0;
            pend_q  <= '0;
        end else begin
            state_q <= state_d;
            blank_q <= blank_d;
            word_q  <= word_d;
            drain_q <= drain_d;
            pend_q  <= pend_d;
        end
    end

    // outputs
    always_comb begin
        strobe_act = (state_q == ST_STROBE);
        burst_last = (state_q == ST_STROBE) && (word_q == 3'd1);
        idle       = (state_q == ST_IDLE);
    end

endmodule

// File: rtl/rrc_word_delay.sv
module rrc_word_delay #(
    parameter int OFS_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_in,
    input  logic             last_in,
    input  logic [OFS_W-1:0] ofs,
    output logic             word_valid,
    output logic             burst_done
);

    localparam int STAGES = (1 << OFS_W) + 1;

    logic [STAGES-1:0] act_q;
    logic [STAGES-1:0] last_q;
    logic [OFS_W:0]    done_idx;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_head
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    act_q[i]  <= 1'b0;
                    last_q[i] <= 1'b0;
                end else begin
                    act_q[i]  <= act_in;
                    last_q[i] <= last_in;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    act_q[i]  <= 1'b0;
                    last_q[i] <= 1'b0;
                end else begin
                    act_q[i]  <= act_q[i-1];
                    last_q[i] <= last_q[i-1];
                end
            end
        end
    end

    assign done_idx   = {1'b0, ofs} + 1'b1;
    assign word_valid = act_q[ofs];
    assign burst_done = last_q[done_idx];

endmodule

// File: rtl/rd_resync_ctl.sv
module rd_resync_ctl
    import rrc_pkg::*;
#(
    parameter int OFS_W    = 2,
    parameter int PEND_MAX = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_cmd,
    input  logic               dqs_low,
    input  logic               cfg_load,
    input  logic [CAS_W-1:0]   cfg_cas,
    input  logic [BURST_W-1:0] cfg_burst,
    input  logic [OFS_W-1:0]   cfg_offset,
    input  logic               cfg_edge,
    output logic               strobe_gate_preset,
    output logic               rd_word_valid,
    output logic               rd_burst_done,
    output logic               resync_on_fall
);

    rrc_mode_t        mode;
    logic [OFS_W-1:0] ofs;
    logic             idle;
    logic             load_en;
    logic             strobe_act;
    logic             burst_last;
    logic [OFS_W:0]   drain_len;

    assign load_en   = idle && cfg_load && !rd_cmd;
    assign drain_len = {1'b0, ofs} + 1'b1;

    rrc_mode_regs #(.OFS_W(OFS_W)) u_mode (
        .clk            (clk),
        .rst_n          (rst_n),
        .load_en        (load_en),
        .cas_in         (cfg_cas),
        .burst_in       (cfg_burst),
        .ofs_in         (cfg_offset),
        .edge_in        (cfg_edge),
        .mode           (mode),
        .ofs            (ofs),
        .resync_on_fall (resync_on_fall)
    );

    rrc_seq_fsm #(.OFS_W(OFS_W), .PEND_MAX(PEND_MAX)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_cmd     (rd_cmd),
        .dqs_low    (dqs_low),
        .blank_len  (blank_cycles(mode.cas)),
        .word_len   (words_per_burst(mode.burst)),
        .drain_len  (drain_len),
        .strobe_act (strobe_act),
        .burst_last (burst_last),
        .idle       (idle)
    );

    rrc_word_delay #(.OFS_W(OFS_W)) u_delay (
        .clk        (clk),
        .rst_n      (rst_n),
        .act_in     (strobe_act),
        .last_in    (burst_last),
        .ofs        (ofs),
        .word_valid (rd_word_valid),
        .burst_done (rd_burst_done)
    );

    assign strobe_gate_preset = strobe_act;

endmodule

// File: rtl/rrc_checker.sv
module rrc_checker (
    input logic clk,
    input logic rst_n,
    input logic dqs_low,
    input logic cfg_load,
    input logic strobe_gate_preset,
    input logic rd_word_valid,
    input logic rd_burst_done,
    input logic resync_on_fall
);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!strobe_gate_preset && !rd_word_valid && !rd_burst_done));

    assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_load) |-> $stable(resync_on_fall));

    assert_preset_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_gate_preset) |-> $past(dqs_low));

    assert_done_after_word_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_burst_done |-> $past(rd_word_valid));

    assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_burst_done && !rd_word_valid) |=> !rd_burst_done);

endmodule

bind rd_resync_ctl rrc_checker u_rrc_checker (
    .clk                (clk),
    .rst_n              (rst_n),
    .dqs_low            (dqs_low),
    .cfg_load           (cfg_load),
    .strobe_gate_preset (strobe_gate_preset),
    .rd_word_valid      (rd_word_valid),
    .rd_burst_done      (rd_burst_done),
    .resync_on_fall     (resync_on_fall)
);

// File: tb/rd_resync_ctl_bench.sv
module rd_resync_ctl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_cmd = 1'b0;
    logic       dqs_low = 1'b0;
    logic       cfg_load = 1'b0;
    logic [1:0] cfg_cas = 2'd0;
    logic [1:0] cfg_burst = 2'd0;
    logic [1:0] cfg_offset = 2'd0;
    logic       cfg_edge = 1'b0;
    logic       strobe_gate_preset;
    logic       rd_word_valid;
    logic       rd_burst_done;
    logic       resync_on_fall;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    rd_resync_ctl u_rd_resync_ctl (
        .clk                (clk),
        .rst_n              (rst_n),
        .rd_cmd             (rd_cmd),
        .dqs_low            (dqs_low),
        .cfg_load           (cfg_load),
        .cfg_cas            (cfg_cas),
        .cfg_burst          (cfg_burst),
        .cfg_offset         (cfg_offset),
        .cfg_edge           (cfg_edge),
        .strobe_gate_preset (strobe_gate_preset),
        .rd_word_valid      (rd_word_valid),
        .rd_burst_done      (rd_burst_done),
        .resync_on_fall     (resync_on_fall)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic load_mode(input logic [1:0] cas, input logic [1:0] bl,
                             input logic [1:0] off, input logic e);
        @(negedge clk);
        cfg_cas = cas; cfg_burst = bl; cfg_offset = off; cfg_edge = e;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
    endtask

    // cycle j: sample outputs at the negedge, then drive inputs for cycle j
    task automatic run_trace(input int len, input logic [47:0] cmd, input logic [47:0] dqs,
                             input logic [47:0] ld, input logic [47:0] ep,
                             input logic [47:0] ev, input logic [47:0] ed,
                             input string rp, input string rv, input string rd);
        int bp = -1; int bv = -1; int bd = -1;
        int ap = 0;  int av = 0;  int ad = 0;
        int xp = 0;  int xv = 0;  int xd = 0;
        for (int j = 0; j < len; j++) begin
            @(negedge clk);
            if (bp < 0 && strobe_gate_preset !== ep[j]) begin
                bp = j; ap = int'(strobe_gate_preset); xp = int'(ep[j]);
            end
            if (bv < 0 && rd_word_valid !== ev[j]) begin
                bv = j; av = int'(rd_word_valid); xv = int'(ev[j]);
            end
            if (bd < 0 && rd_burst_done !== ed[j]) begin
                bd = j; ad = int'(rd_burst_done); xd = int'(ed[j]);
            end
            rd_cmd   = cmd[j];
            dqs_low  = dqs[j];
            cfg_load = ld[j];
        end
        chk(bp < 0, rp, $sformatf("preset at cycle %0d", bp), ap, xp);
        chk(bv < 0, rv, $sformatf("word_valid at cycle %0d", bv), av, xv);
        chk(bd < 0, rd, $sformatf("burst_done at cycle %0d", bd), ad, xd);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [47:0] cmd, dqs, ld, ep, ev, ed;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(strobe_gate_preset == 1'b0, "R1", "preset after reset", int'(strobe_gate_preset), 0);
        chk(rd_word_valid == 1'b0, "R1", "word_valid after reset", int'(rd_word_valid), 0);
        chk(rd_burst_done == 1'b0, "R1", "burst_done after reset", int'(rd_burst_done), 0);
        chk(resync_on_fall == 1'b0, "R1", "resync_on_fall after reset", int'(resync_on_fall), 0);

        // sweep every mode: R3 edge choice, R4 blanking, R5/R6/R7 windows
        for (int cas = 0; cas < 4; cas++) begin
            for (int bl = 0; bl < 4; bl++) begin
                for (int off = 0; off < 4; off++) begin
                    for (int e = 0; e < 2; e++) begin
                        int b, h, c, len;
                        logic exp_fall;
                        load_mode(2'(cas), 2'(bl), 2'(off), 1'(e));
                        exp_fall = 1'(e) ^ (cas == 1);
                        chk(resync_on_fall == exp_fall, "R3", "resync_on_fall",
                            int'(resync_on_fall), int'(exp_fall));
                        b = (cas >= 2) ? 2 : 1;
                        h = (bl == 0) ? 1 : ((bl == 1) ? 2 : 4);
                        c = b + 1;
                        len = b + h + off + 7;
                        cmd = '0; dqs = '0; ld = '0; ep = '0; ev = '0; ed = '0;
                        cmd[0] = 1'b1;
                        for (int j = 0; j < 48; j++) begin
                            if (j <= c) dqs[j] = 1'b1;
                            if (j >= c + 1 && j <= c + h) ep[j] = 1'b1;
                            if (j >= c + 2 + off && j <= c + 1 + off + h) ev[j] = 1'b1;
                            if (j == c + 2 + off + h) ed[j] = 1'b1;
                        end
                        run_trace(len, cmd, dqs, ld, ep, ev, ed, "R5 R4", "R6", "R7");
                    end
                end
            end
        end

        // R8: one queued read chains right behind the first
        load_mode(2'd0, 2'd1, 2'd1, 1'b0);
        cmd = '0; dqs = '0; ld = '0; ep = '0; ev = '0; ed = '0;
        cmd[0] = 1'b1; cmd[2] = 1'b1;
        dqs[2:0] = 3'b111;
        ep[6:3] = 4'hF; ev[8:5] = 4'hF; ed[7] = 1'b1; ed[9] = 1'b1;
        run_trace(14, cmd, dqs, ld, ep, ev, ed, "R8", "R8", "R8");

        // R8: queue saturates at three extra reads, the rest are dropped
        load_mode(2'd2, 2'd0, 2'd0, 1'b0);
        cmd = '0; dqs = '0; ld = '0; ep = '0; ev = '0; ed = '0;
        cmd[5:0] = 6'h3F;
        dqs[6] = 1'b1;
        ep[10:7] = 4'hF; ev[11:8] = 4'hF; ed[12:9] = 4'hF;
        run_trace(16, cmd, dqs, ld, ep, ev, ed, "R8", "R8", "R8");

        // R9: read during drain restarts blanking at once; R4 blank still applies
        load_mode(2'd0, 2'd0, 2'd3, 1'b0);
        cmd = '0; dqs = '0; ld = '0; ep = '0; ev = '0; ed = '0;
        cmd[0] = 1'b1; cmd[5] = 1'b1;
        dqs[2:0] = 3'b111; dqs[6] = 1'b1; dqs[7] = 1'b1;
        ep[3] = 1'b1; ep[8] = 1'b1;
        ev[7] = 1'b1; ev[12] = 1'b1;
        ed[8] = 1'b1; ed[13] = 1'b1;
        run_trace(18, cmd, dqs, ld, ep, ev, ed, "R9 R4", "R9", "R9");

        // R2: load requests while busy or together with a read are ignored
        load_mode(2'd0, 2'd0, 2'd0, 1'b0);
        cfg_cas = 2'd1; cfg_burst = 2'd2; cfg_offset = 2'd3; cfg_edge = 1'b0;
        cmd = '0; dqs = '0; ld = '0; ep = '0; ev = '0; ed = '0;
        cmd[0] = 1'b1; dqs[2:0] = 3'b111; ld[5:0] = 6'h3F;
        ep[3] = 1'b1; ev[4] = 1'b1; ed[5] = 1'b1;
        run_trace(7, cmd, dqs, ld, ep, ev, ed, "R2", "R2", "R2");
        chk(resync_on_fall == 1'b0, "R2", "resync_on_fall after ignored load",
            int'(resync_on_fall), 0);
        cmd = '0; dqs = '0; ld = '0; ep = '0; ev = '0; ed = '0;
        cmd[0] = 1'b1; dqs[2:0] = 3'b111;
        ep[3] = 1'b1; ev[4] = 1'b1; ed[5] = 1'b1;
        run_trace(9, cmd, dqs, ld, ep, ev, ed, "R2", "R2", "R2");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule